// File: doc/BRIEF.md
# 64Fs to 48Fs Serial Audio Reformatter

This block takes a stereo serial audio stream whose bit clock runs at 64 times the sample rate and re-emits the same samples in a 48-times framing. Each output channel occupies a 24-bit slot and carries a 16-bit word placed against the end of that slot. The input follows the common two-channel format: a word clock that is low for left, and a most significant bit that arrives one bit clock after each word-clock edge in a 32-bit channel slot. The output drives a DAC filter that expects a 48Fs bit clock, a word clock that is high for left, and right-justified 16-bit data.

Both the incoming and the outgoing streams are tied to one system clock at 384 times the sample rate. The incoming serial clocks are therefore oversampled: one input bit lasts six system clocks, and one output bit lasts eight. The block synchronises the input pins, captures bits on detected rising edges of the input bit clock, and keeps the 16 most significant bits of each channel. It latches a complete left/right pair, then shifts that pair out in the next output frame. The output bit clock and word clock are generated from one free-running frame counter.

Top module: `aud_48fs_reformatter`

## Requirements
- R1: `out_bclk` is the system clock divided by 8. It is low for 4 system clocks and high for 4, and it is low during reset.
- R2: `out_lrck` is high for 24 output bit periods (left) and low for 24 (right). An output frame is 384 system clocks and begins with the left half. `out_lrck` changes only together with a falling edge of `out_bclk`, and it is high during reset.
- R3: `out_sdata` changes only together with a falling edge of `out_bclk`.
- R4: The first 8 bit periods of every 24-bit output half carry 0.
- R5: The last 16 bit periods of a half carry that channel's 16-bit sample, most significant bit first.
- R6: On the input, `in_lrck` low selects left and high selects right. Bits are taken on rising edges of `in_bclk`. The first rising edge after a word-clock change is skipped, and the next one carries the sample's most significant bit.
- R7: Only the first 16 captured bits of each 32-bit input channel slot are used. The remaining bits of the slot, and the bit on the skipped edge, have no effect on the output.
- R8: A complete input pair appears in the output frame that follows the one in which its right word finishes. Successive input pairs appear in order, one pair per output frame.
- R9: During reset, `out_sdata` is 0. Output frames that begin before any complete input pair has arrived carry zero in both channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 384 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| in_bclk | input | 1 | Input bit clock, 64 times the sample rate |
| in_lrck | input | 1 | Input word clock, low for left |
| in_sdata | input | 1 | Input serial data, MSB first |
| out_bclk | output | 1 | Output bit clock, system clock divided by 8 |
| out_lrck | output | 1 | Output word clock, high for left |
| out_sdata | output | 1 | Output serial data, 16 bits right-justified |

## Verification
A corrupted frame counter shows up within one output bit period. The symptom is a bit clock phase that is not 4/4, or a word-clock edge that lands on the wrong bit count. A fault in the input bit counter or shift register shows up in the first pair it corrupts. That pair surfaces one output frame later as a wrong 16-bit value, a shifted bit, or junk from the lower half of the input slot leaking into the word. Walking-one and walking-zero samples make any swapped or dropped bit position appear in the first affected frame. A fault in the holding register or the frame-start load shows up as a repeated or skipped pair in the ordered sequence.

// File: rtl/aud_reform_pkg.sv
package aud_reform_pkg;

    // Width of one audio sample as delivered to the DAC filter.
    localparam int SAMPLE_W = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // One stereo pair, moved as a unit between the capture and playback sides.
    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

endpackage

// File: rtl/reform_in_deser.sv
module reform_in_deser
    import aud_reform_pkg::*;
#(
    parameter int IN_SLOT = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk_pin,
    input  logic  lrck_pin,
    input  logic  sdata_pin,
    output pair_t hold_o
);

    localparam int CNT_W = $clog2(IN_SLOT) + 1;
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_SAT   = '1;

    typedef struct packed {
        logic [1:0]       sync_b;   // two-stage synchroniser, bit clock
        logic [1:0]       sync_l;   // two-stage synchroniser, word clock
        logic [1:0]       sync_d;   // two-stage synchroniser, data
        logic             b_last;   // synchronised bit clock, previous cycle
        logic             lr_last;  // word clock seen at the previous bit-clock rise
        logic [CNT_W-1:0] bit_cnt;  // position within the current channel slot
        sample_t          shreg;    // incoming sample being assembled
        sample_t          left_s;   // finished left word awaiting its partner
        pair_t            hold;     // last complete pair
    } dsr_t;

    dsr_t st_d, st_q;

    always_comb begin
        logic    rise_v;
        logic    lr_v;
        logic    dat_v;
        sample_t word_v;

        st_d = st_q;
        st_d.sync_b = {st_q.sync_b[0], bclk_pin};
        st_d.sync_l = {st_q.sync_l[0], lrck_pin};
        st_d.sync_d = {st_q.sync_d[0], sdata_pin};
        st_d.b_last = st_q.sync_b[1];

        rise_v = st_q.sync_b[1] & ~st_q.b_last;
        lr_v   = st_q.sync_l[1];
        dat_v  = st_q.sync_d[1];
        word_v = {st_q.shreg[SAMPLE_W-2:0], dat_v};

        if (rise_v) begin
            if (lr_v != st_q.lr_last) begin
                // Word-clock change: this edge carries the tail of the
                // previous slot, the MSB follows on the next edge.
                st_d.bit_cnt = '0;
                st_d.lr_last = lr_v;
            end else if (st_q.bit_cnt != CNT_SAT) begin
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end

            if (st_d.bit_cnt >= CNT_FIRST && st_d.bit_cnt <= CNT_LAST) begin
                st_d.shreg = word_v;
                if (st_d.bit_cnt == CNT_LAST) begin
                    if (!lr_v) begin
                        st_d.left_s = word_v;
                    end else begin
                        st_d.hold.left  = st_q.left_s;
                        st_d.hold.right = word_v;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.lr_last <= 1'b1;
            st_q.bit_cnt <= CNT_SAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/reform_frame_timer.sv
module reform_frame_timer #(
    parameter int FRAME_SYS = 384,
    parameter int CNT_W     = $clog2(FRAME_SYS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] phase_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_SYS - 1);

    logic [CNT_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/reform_out_ser.sv
module reform_out_ser
    import aud_reform_pkg::*;
#(
    parameter int OUT_SLOT = 24,
    parameter int OBIT_DIV = 8,
    parameter int CNT_W    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] phase_i,
    input  pair_t            pair_i,
    output logic             bclk_o,
    output logic             lrck_o,
    output logic             sdata_o
);

    localparam int PAD      = OUT_SLOT - SAMPLE_W;
    localparam int HALF_SYS = OUT_SLOT * OBIT_DIV;
    localparam int HI_FROM  = OBIT_DIV / 2;

    typedef struct packed {
        pair_t word;   // pair being played in this frame
        logic  bclk;
        logic  lrck;
        logic  sdata;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        logic [31:0] c_v;
        logic [31:0] rel_v;
        logic [31:0] pos_v;
        logic [31:0] sub_v;
        logic        first_v;
        sample_t     sel_v;
        sample_t     shf_v;

        st_d    = st_q;
        c_v     = 32'(phase_i);
        first_v = (c_v < HALF_SYS);
        rel_v   = first_v ? c_v : c_v - HALF_SYS;
        pos_v   = rel_v / OBIT_DIV;
        sub_v   = rel_v % OBIT_DIV;
        sel_v   = first_v ? st_q.word.left : st_q.word.right;
        shf_v   = '0;

        st_d.bclk = (sub_v >= HI_FROM);
        st_d.lrck = first_v;
        if (pos_v >= PAD) begin
            shf_v      = sel_v >> (SAMPLE_W - 1 - (pos_v - PAD));
            st_d.sdata = shf_v[0];
        end else begin
            st_d.sdata = 1'b0;
        end

        // Take a fresh pair at the start of each frame; the leading pad
        // bits give it time to settle before the first data bit.
        if (c_v == 0) begin
            st_d.word = pair_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.lrck <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o  = st_q.bclk;
    assign lrck_o  = st_q.lrck;
    assign sdata_o = st_q.sdata;

endmodule

// File: rtl/aud_48fs_reformatter.sv
module aud_48fs_reformatter
    import aud_reform_pkg::*;
#(
    parameter int IN_SLOT  = 32,
    parameter int OUT_SLOT = 24,
    parameter int OBIT_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bclk,
    input  logic in_lrck,
    input  logic in_sdata,
    output logic out_bclk,
    output logic out_lrck,
    output logic out_sdata
);

    localparam int FRAME_SYS = 2 * OUT_SLOT * OBIT_DIV;
    localparam int CNT_W     = $clog2(FRAME_SYS);

    pair_t            hold_w;
    logic [CNT_W-1:0] phase_w;

    reform_in_deser #(
        .IN_SLOT (IN_SLOT)
    ) deser_i (
        .clk       (clk),
        .rst       (rst),
        .bclk_pin  (in_bclk),
        .lrck_pin  (in_lrck),
        .sdata_pin (in_sdata),
        .hold_o    (hold_w)
    );

    reform_frame_timer #(
        .FRAME_SYS (FRAME_SYS),
        .CNT_W     (CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_w)
    );

    reform_out_ser #(
        .OUT_SLOT (OUT_SLOT),
        .OBIT_DIV (OBIT_DIV),
        .CNT_W    (CNT_W)
    ) ser_i (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_w),
        .pair_i  (hold_w),
        .bclk_o  (out_bclk),
        .lrck_o  (out_lrck),
        .sdata_o (out_sdata)
    );

endmodule

// File: rtl/reform_checker.sv
module reform_checker
    import aud_reform_pkg::*;
#(
    parameter int OUT_SLOT = 24,
    parameter int OBIT_DIV = 8
) (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic lrck,
    input logic sdata
);

    localparam int POS_W = $clog2(OUT_SLOT) + 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(OUT_SLOT - 1);
    localparam logic [POS_W-1:0] PAD_POS  = POS_W'(OUT_SLOT - SAMPLE_W);
    localparam logic [7:0]       HALF_DIV = 8'(OBIT_DIV / 2);

    logic             b_prev_q;
    logic             lr_prev_q;
    logic             sd_prev_q;
    logic             seen_q;
    logic [7:0]       run_q;
    logic [POS_W-1:0] pos_q;

    logic b_chg, b_fall, lr_chg, sd_chg;
    assign b_chg  = (bclk != b_prev_q);
    assign b_fall = b_prev_q & ~bclk;
    assign lr_chg = (lrck != lr_prev_q);
    assign sd_chg = (sdata != sd_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            b_prev_q  <= 1'b0;
            lr_prev_q <= 1'b1;
            sd_prev_q <= 1'b0;
            seen_q    <= 1'b0;
            run_q     <= '0;
            pos_q     <= '0;
        end else begin
            b_prev_q  <= bclk;
            lr_prev_q <= lrck;
            sd_prev_q <= sdata;
            if (b_chg) begin
                run_q  <= 8'd1;
                seen_q <= 1'b1;
            end else if (run_q != 8'hFF) begin
                run_q <= run_q + 8'd1;
            end
            if (b_fall) begin
                pos_q <= lr_chg ? '0 : pos_q + 1'b1;
            end
        end
    end

    AST_BCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (b_chg && seen_q) |-> (run_q == HALF_DIV)); // R1

    AST_LRCK_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        lr_chg |-> b_fall); // R2

    AST_HALF_LENGTH: assert property (@(posedge clk) disable iff (rst)
        lr_chg |-> (pos_q == LAST_POS)); // R2

    AST_SDATA_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        sd_chg |-> b_fall); // R3

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!b_fall && (pos_q < PAD_POS)) |-> !sdata); // R4

endmodule

bind aud_48fs_reformatter reform_checker #(
    .OUT_SLOT (OUT_SLOT),
    .OBIT_DIV (OBIT_DIV)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .bclk  (out_bclk),
    .lrck  (out_lrck),
    .sdata (out_sdata)
);

// File: tb/aud_48fs_reformatter_tb_top.sv
module aud_48fs_reformatter_tb_top;

    localparam int NPAIR = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_bclk = 1'b0;
    logic in_lrck = 1'b1;
    logic in_sdata = 1'b0;
    logic out_bclk, out_lrck, out_sdata;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    aud_48fs_reformatter dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_bclk   (in_bclk),
        .in_lrck   (in_lrck),
        .in_sdata  (in_sdata),
        .out_bclk  (out_bclk),
        .out_lrck  (out_lrck),
        .out_sdata (out_sdata)
    );

    function automatic logic [15:0] pat_l(int n);
        if (n < 16)       return 16'(1) << n;
        else if (n < 32)  return ~(16'(1) << (n - 16));
        else if (n == 32) return 16'hFFFF;
        else if (n == 33) return 16'h0000;
        else if (n == 34) return 16'h8000;
        else              return 16'(n * 947) ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] pat_r(int n);
        if (n < 16)       return ~(16'(1) << n);
        else if (n < 32)  return 16'(1) << (n - 16);
        else if (n == 32) return 16'h0000;
        else if (n == 33) return 16'hFFFF;
        else if (n == 34) return 16'h0001;
        else              return 16'(n * 497) + 16'h5A0F;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // I2S-style input: 64 slots per frame, 6 system clocks per slot.
    // Unused slot positions carry 1 so any leakage shows up (R7).
    task automatic send_frame(input int n);
        for (int k = 0; k < 64; k++) begin
            int j = k % 32;
            logic [15:0] w = (k < 32) ? pat_l(n) : pat_r(n);
            @(negedge clk);
            in_bclk  = 1'b0;
            in_lrck  = (k >= 32);
            in_sdata = (j >= 1 && j <= 16) ? w[16 - j] : 1'b1;
            repeat (3) @(negedge clk);
            in_bclk = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    // Output monitor state
    logic        prev_b = 1'b0;
    logic        last_lr = 1'b0;
    bit          have_rise = 0;
    bit          started = 0;
    bit          synced = 0;
    int          cyc = 0;
    int          pos = 0;
    int          nxt = 0;
    int          zero_frames = 0;
    logic [23:0] sh = '0;
    logic [15:0] left_v = '0;

    task automatic pair_done(input logic [15:0] l, input logic [15:0] r);
        if (!synced) begin
            if (l == pat_l(0) && r == pat_r(0)) begin
                synced = 1;
                nxt = 1;
                chk(zero_frames >= 1, "R8 first pair after zero frames", zero_frames, 1);
            end else begin
                zero_frames++;
                chk(l == 16'h0 && r == 16'h0, "R9 frame before first pair", {l, r}, 0);
            end
        end else if (nxt < NPAIR) begin
            chk(l == pat_l(nxt), "R5 R6 left word", l, pat_l(nxt));
            chk(r == pat_r(nxt), "R5 R7 right word", r, pat_r(nxt));
            nxt++;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc++;
            if (out_bclk && !prev_b) begin
                if (have_rise) chk(cyc == 8, "R1 bit clock period", cyc, 8);
                have_rise = 1;
                cyc = 0;
                if (out_lrck != last_lr) begin
                    if (started) chk(pos == 24, "R2 half length", pos, 24);
                    else chk(out_lrck == 1'b1, "R2 first half is left", out_lrck, 1);
                    started = 1;
                    pos = 0;
                    last_lr = out_lrck;
                end
                sh = {sh[22:0], out_sdata};
                pos++;
                if (pos == 24) begin
                    chk(sh[23:16] == 8'h00, "R4 leading pad", sh[23:16], 0);
                    if (out_lrck) left_v = sh[15:0];
                    else pair_done(left_v, sh[15:0]);
                end
            end
            prev_b = out_bclk;
        end
    end

    // R3: data must be stable at every rising bit-clock edge window
    always @(negedge clk) begin
        if (!rst && !done && out_bclk && prev_b) begin
            if (tests < 60000) begin
                // high phase: data equals the last value shifted in
                chk(out_sdata == sh[0], "R3 data stable while clock high", out_sdata, sh[0]);
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(out_bclk == 1'b0, "R1 bclk low in reset", out_bclk, 0);
        chk(out_lrck == 1'b1, "R2 lrck high in reset", out_lrck, 1);
        chk(out_sdata == 1'b0, "R9 sdata low in reset", out_sdata, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        for (int n = 0; n < NPAIR + 3; n++) send_frame(n);
        repeat (768) @(negedge clk);
        done = 1;
        chk(synced, "R8 sequence locked", synced, 1);
        chk(nxt == NPAIR, "R8 all pairs in order", nxt, NPAIR);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        done = 1;
        tests++;
        fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", nxt, NPAIR);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule